// File: doc/BRIEF.md
# Exception Vector and Priority Resolver

This block sits at the front of a processor's exception entry logic. In each cycle it looks at all pending events and picks one to service. The events are a reset request, a debug-break request, a general exception carrying its own event code, an external interrupt level on four pins, and thirteen on-chip interrupt sources. The on-chip sources are eight DMA channel-end requests, one DMA address-error request and four serial-port requests. When an event is accepted, the block pulses a taken strobe. On that same cycle it presents the jump address and records a 12-bit event code. Reset and exception codes go into an exception-code register. Interrupt codes go into an interrupt-code register.

Interrupts are arbitrated in two steps. The first step compares priority level. Each on-chip source has a 4-bit level supplied by software, and the external request uses its pin value as its level. Among requests that share the top level, a fixed order decides, and the lowest order number wins. An interrupt is accepted only if its level is strictly above the current mask level, so a level of 0 never wins. Reset outranks everything. A debug break outranks a general exception, and every exception outranks every interrupt. The requester lowers its request once it sees the strobe. The block ignores all requests in the cycle that directly follows an accepted event.

Top module: `exc_resolver`

## Requirements
- R1: A reset request wins over every other request. One cycle later, taken is 1, target PC is H'A0000000 and the exception-code register holds H'000. The interrupt-code register is unchanged.
- R2: A general exception, with no reset or debug break pending, wins over all interrupts. Target PC is vector base + H'100 and the exception-code register takes excCode. The interrupt-code register is unchanged.
- R3: A debug break, with no reset pending, wins over general exceptions and interrupts and writes code H'1E0 to the exception-code register. Target PC is the debug base when dbgRedirect is 1, and vector base + H'100 when it is 0.
- R4: An accepted interrupt sets target PC to vector base + H'600 and writes its code to the interrupt-code register. The exception-code register is unchanged.
- R5: Among eligible interrupts, the one with the highest level wins.
- R6: Among eligible interrupts at the same level, the order from first to last is: external, DMA channel-end 0 to 7 (perReq bits 0 to 7), DMA address error (bit 8), serial receive error (bit 9), serial receive data (bit 10), serial break (bit 11), serial transmit data (bit 12). On-chip source i takes its level from perLevel[4i+3:4i].
- R7: On-chip interrupt codes are as follows. DMA channel-end codes are H'640, H'660, H'680 and H'6A0 for channels 0 to 3, and H'780, H'7A0, H'7C0 and H'7E0 for channels 4 to 7. DMA address error is H'6C0. The serial codes are H'700 for receive error, H'720 for receive data, H'740 for break and H'760 for transmit data.
- R8: The external request level is the value on extLevel, with 0 meaning no request. Its code is H'200 + H'20 × (15 − level).
- R9: An interrupt whose level is not strictly greater than imask is never accepted. A level of 0 is therefore never accepted.
- R10: taken is high for exactly one cycle per accepted event, and never on two cycles in a row. Requests present on the cycle right after a taken pulse are ignored. Target PC and both code registers change only on the cycle taken is high, and they hold between events.
- R11: After reset, taken, target PC and both code registers are 0. When no request is eligible, taken stays 0 and the outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low block reset |
| resetReq | input | 1 | Reset event request |
| brkReq | input | 1 | Debug-break request |
| excReq | input | 1 | General exception request |
| excCode | input | 12 | Event code of the general exception |
| extLevel | input | 4 | External interrupt level, 0 = none |
| perReq | input | 13 | On-chip interrupt requests, order as in R6 |
| perLevel | input | 52 | 4-bit programmed level per on-chip source |
| imask | input | 4 | Current interrupt mask level |
| vbr | input | 32 | Vector base |
| dbr | input | 32 | Debug base |
| dbgRedirect | input | 1 | Send debug breaks to the debug base |
| taken | output | 1 | One-cycle accept strobe |
| targetPc | output | 32 | Jump address of the last accepted event |
| expCode | output | 12 | Exception-code register |
| intCode | output | 12 | Interrupt-code register |

## Verification
Each result is registered once. Requests present at a rising edge with taken low show up in taken, targetPc and the code registers right after that same edge. The next edge then returns taken to 0 while the values hold. The bench drives inputs on the falling edge and samples one time unit after the following rising edge. It checks the accepted event in that sample. It then clears the requests and checks one edge later that the strobe has dropped and the values held. Vectors that must not be accepted are checked at the same point against unchanged outputs.

// File: rtl/exc_resolver_pkg.sv
package exc_resolver_pkg;
  localparam int NPER  = 13;
  localparam int LVLW  = 4;
  localparam int CODEW = 12;

  typedef enum logic [1:0] {EV_RST, EV_BRK, EV_EXC, EV_INT} evClass_e;

  typedef struct packed {
    logic             load;
    evClass_e         cls;
    logic [CODEW-1:0] code;
  } evStrobe_t;

  // Event code of on-chip source idx (order: DMA end 0..7, DMA error, serial x4)
  function automatic logic [CODEW-1:0] perCode(input int idx);
    logic [CODEW-1:0] c;
    if (idx < 4)       c = 12'h640 + CODEW'(idx * 32);
    else if (idx < 8)  c = 12'h780 + CODEW'((idx - 4) * 32);
    else if (idx == 8) c = 12'h6C0;
    else               c = 12'h700 + CODEW'((idx - 9) * 32);
    return c;
  endfunction

  function automatic logic [CODEW-1:0] extCode(input logic [LVLW-1:0] lvl);
    logic [LVLW-1:0] inv;
    inv = 4'hF - lvl;
    return {3'b000, inv, 5'b00000} + 12'h200;
  endfunction
endpackage

// File: rtl/exc_resolver_ctrl.sv
module exc_resolver_ctrl
  import exc_resolver_pkg::*;
#(
  parameter logic [CODEW-1:0] BRK_CODE = 12'h1E0,
  parameter logic [CODEW-1:0] RST_CODE = 12'h000
) (
  input  logic                 takenQ,
  input  logic                 resetReq,
  input  logic                 brkReq,
  input  logic                 excReq,
  input  logic [CODEW-1:0]     excCode,
  input  logic [LVLW-1:0]      extLevel,
  input  logic [NPER-1:0]      perReq,
  input  logic [NPER*LVLW-1:0] perLevel,
  input  logic [LVLW-1:0]      imask,
  output evStrobe_t            stb
);
  logic [CODEW-1:0] codeTab [NPER];

  genvar g;
  generate
    for (g = 0; g < NPER; g++) begin : g_code
      assign codeTab[g] = perCode(g);
    end
  endgenerate

  logic [LVLW-1:0]  bestLvl;
  logic             bestHit;
  logic [CODEW-1:0] bestCode;

  // Strictly-greater compare keeps the earlier (lower order) source on ties
  // and rejects anything at or below the mask, including level 0.
  always_comb begin
    bestLvl  = imask;
    bestHit  = 1'b0;
    bestCode = '0;
    if (extLevel > bestLvl) begin
      bestLvl  = extLevel;
      bestHit  = 1'b1;
      bestCode = extCode(extLevel);
    end
    for (int i = 0; i < NPER; i++) begin
      if (perReq[i] && (perLevel[i*LVLW +: LVLW] > bestLvl)) begin
        bestLvl  = perLevel[i*LVLW +: LVLW];
        bestHit  = 1'b1;
        bestCode = codeTab[i];
      end
    end
  end

  always_comb begin
    stb.load = 1'b0;
    stb.cls  = EV_INT;
    stb.code = bestCode;
    if (!takenQ) begin
      if (resetReq) begin
        stb.load = 1'b1; stb.cls = EV_RST; stb.code = RST_CODE;
      end else if (brkReq) begin
        stb.load = 1'b1; stb.cls = EV_BRK; stb.code = BRK_CODE;
      end else if (excReq) begin
        stb.load = 1'b1; stb.cls = EV_EXC; stb.code = excCode;
      end else if (bestHit) begin
        stb.load = 1'b1; stb.cls = EV_INT;
      end
    end
  end
endmodule

// File: rtl/exc_resolver_dp.sv
module exc_resolver_dp
  import exc_resolver_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'hA000_0000,
  parameter logic [31:0] EXC_OFS  = 32'h0000_0100,
  parameter logic [31:0] INT_OFS  = 32'h0000_0600
) (
  input  logic             clk,
  input  logic             rstN,
  input  evStrobe_t        stb,
  input  logic [31:0]      vbr,
  input  logic [31:0]      dbr,
  input  logic             dbgRedirect,
  output logic             takenQ,
  output logic [31:0]      targetPc,
  output logic [CODEW-1:0] expCode,
  output logic [CODEW-1:0] intCode
);
  logic [31:0] nextPc;

  always_comb begin
    unique case (stb.cls)
      EV_RST:  nextPc = RESET_PC;
      EV_BRK:  nextPc = dbgRedirect ? dbr : (vbr + EXC_OFS);
      EV_EXC:  nextPc = vbr + EXC_OFS;
      default: nextPc = vbr + INT_OFS;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      takenQ   <= 1'b0;
      targetPc <= '0;
      expCode  <= '0;
      intCode  <= '0;
    end else begin
      takenQ <= stb.load;
      if (stb.load) begin
        targetPc <= nextPc;
        if (stb.cls == EV_INT) intCode <= stb.code;
        else                   expCode <= stb.code;
      end
    end
  end
endmodule

// File: rtl/exc_resolver.sv
module exc_resolver
  import exc_resolver_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'hA000_0000,
  parameter logic [11:0] BRK_CODE = 12'h1E0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         resetReq,
  input  logic         brkReq,
  input  logic         excReq,
  input  logic [11:0]  excCode,
  input  logic [3:0]   extLevel,
  input  logic [12:0]  perReq,
  input  logic [51:0]  perLevel,
  input  logic [3:0]   imask,
  input  logic [31:0]  vbr,
  input  logic [31:0]  dbr,
  input  logic         dbgRedirect,
  output logic         taken,
  output logic [31:0]  targetPc,
  output logic [11:0]  expCode,
  output logic [11:0]  intCode
);
  evStrobe_t stb;
  logic      takenQ;

  exc_resolver_ctrl #(.BRK_CODE(BRK_CODE)) u_ctrl (
    .takenQ(takenQ), .resetReq(resetReq), .brkReq(brkReq), .excReq(excReq),
    .excCode(excCode), .extLevel(extLevel), .perReq(perReq),
    .perLevel(perLevel), .imask(imask), .stb(stb)
  );

  exc_resolver_dp #(.RESET_PC(RESET_PC)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .vbr(vbr), .dbr(dbr),
    .dbgRedirect(dbgRedirect), .takenQ(takenQ), .targetPc(targetPc),
    .expCode(expCode), .intCode(intCode)
  );

  assign taken = takenQ;
endmodule

// File: rtl/exc_resolver_chk.sv
module exc_resolver_chk (
  input logic        clk,
  input logic        rstN,
  input logic        resetReq,
  input logic        brkReq,
  input logic        excReq,
  input logic [3:0]  extLevel,
  input logic [12:0] perReq,
  input logic        taken,
  input logic [31:0] targetPc,
  input logic [11:0] expCode,
  input logic [11:0] intCode
);
  // R10: strobe never on two consecutive cycles
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    taken |=> !taken);

  // R10: outputs only move on a taken cycle
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !taken |-> ($stable(targetPc) && $stable(expCode) && $stable(intCode)));

  // R1: reset request lands at the fixed address with code zero
  a_r1_reset_entry: assert property (@(posedge clk) disable iff (!rstN)
    (resetReq && !taken) |=> (taken && targetPc == 32'hA000_0000 && expCode == 12'h000));

  // R4: an interrupt code update leaves the exception code alone
  a_r4_int_keeps_exp: assert property (@(posedge clk) disable iff (!rstN)
    (taken && intCode != $past(intCode)) |-> $stable(expCode));

  // R11: with nothing requested, nothing is taken
  a_r11_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!resetReq && !brkReq && !excReq && extLevel == 4'd0 && perReq == '0) |=> !taken);
endmodule

bind exc_resolver exc_resolver_chk u_chk (
  .clk(clk), .rstN(rstN), .resetReq(resetReq), .brkReq(brkReq),
  .excReq(excReq), .extLevel(extLevel), .perReq(perReq), .taken(taken),
  .targetPc(targetPc), .expCode(expCode), .intCode(intCode)
);

// File: tb/exc_resolver_test.sv
module exc_resolver_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resetReq = 0, brkReq = 0, excReq = 0, dbgRedirect = 0;
  logic [11:0] excCode = 0;
  logic [3:0]  extLevel = 0, imask = 0;
  logic [12:0] perReq = 0;
  logic [51:0] perLevel = 0;
  logic [31:0] vbr = 0, dbr = 0;
  logic        taken;
  logic [31:0] targetPc;
  logic [11:0] expCode, intCode;

  int nChecks = 0, nFails = 0;
  logic [31:0] mPc;
  logic [11:0] mExp, mInt;
  logic        mTake;
  string       mTag;

  localparam logic [11:0] CODES [13] = '{12'h640, 12'h660, 12'h680, 12'h6A0,
    12'h780, 12'h7A0, 12'h7C0, 12'h7E0, 12'h6C0, 12'h700, 12'h720, 12'h740, 12'h760};

  exc_resolver uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 190000);
    nFails++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Model of the expected outcome from the current inputs.
  task automatic model();
    int maxL, win;
    mTake = 1'b1;
    if (resetReq) begin
      mTag = "R1"; mPc = 32'hA000_0000; mExp = 12'h000;
    end else if (brkReq) begin
      mTag = "R3"; mPc = dbgRedirect ? dbr : vbr + 32'h100; mExp = 12'h1E0;
    end else if (excReq) begin
      mTag = "R2"; mPc = vbr + 32'h100; mExp = excCode;
    end else begin
      mTag = "R5";
      maxL = 0;
      if (int'(extLevel) > int'(imask)) maxL = int'(extLevel);
      for (int i = 0; i < 13; i++)
        if (perReq[i] && int'(perLevel[i*4 +: 4]) > int'(imask) &&
            int'(perLevel[i*4 +: 4]) > maxL) maxL = int'(perLevel[i*4 +: 4]);
      if (maxL == 0) begin
        mTake = 1'b0; mTag = "R9";
      end else begin
        mPc = vbr + 32'h600;
        if (int'(extLevel) == maxL) mInt = 12'(32'h200 + (15 - maxL) * 32);
        else begin
          win = -1;
          for (int i = 12; i >= 0; i--)
            if (perReq[i] && int'(perLevel[i*4 +: 4]) == maxL) win = i;
          mInt = CODES[win];
        end
      end
    end
  endtask

  // Inputs already set before the rising edge; check after it, then idle one cycle.
  task automatic apply(input string tag);
    string t;
    model();
    t = (tag == "") ? mTag : tag;
    @(posedge clk); #1;
    chk(taken == mTake, t, "taken", 32'(taken), 32'(mTake));
    chk(targetPc == mPc, t, "targetPc", targetPc, mPc);
    chk(expCode == mExp, t, "expCode", 32'(expCode), 32'(mExp));
    chk(intCode == mInt, t, "intCode", 32'(intCode), 32'(mInt));
    @(negedge clk);
    resetReq = 0; brkReq = 0; excReq = 0; extLevel = 0; perReq = 0;
    @(posedge clk); #1;
    chk(taken == 1'b0, "R10", "taken after event", 32'(taken), 32'd0);
    chk(targetPc == mPc && expCode == mExp && intCode == mInt, "R10", "hold",
        targetPc, mPc);
    @(negedge clk);
  endtask

  function automatic logic [51:0] allLvl(input logic [3:0] l);
    logic [51:0] v;
    for (int i = 0; i < 13; i++) v[i*4 +: 4] = l;
    return v;
  endfunction

  initial begin
    int seed;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    mPc = 0; mExp = 0; mInt = 0;
    vbr = 32'h8C00_0000; dbr = 32'h1234_5670;
    repeat (3) @(posedge clk);
    #1;
    chk(taken == 0 && targetPc == 0 && expCode == 0 && intCode == 0, "R11",
        "reset state", targetPc, 32'd0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);

    // R11: idle cycles change nothing
    apply("R11");

    // R4/R7: DMA channel 5 alone
    perReq = 13'h0020; perLevel = allLvl(4'd3); apply("R7");
    // R7: serial break alone
    perReq = 13'h0800; apply("R7");
    // R6/R8: tie at level 7, external first; code 0x300
    perReq = 13'h1FFF; perLevel = allLvl(4'd7); extLevel = 4'd7; apply("R6");
    // R6: tie without external, channel 0 wins
    perReq = 13'h1FFF; perLevel = allLvl(4'd7); apply("R6");
    // R5: higher level on a late source beats earlier lower ones
    perReq = 13'h1003; perLevel = allLvl(4'd2); perLevel[48 +: 4] = 4'd9;
    apply("R5");
    // R8: external level 15 -> 0x200
    extLevel = 4'd15; apply("R8");
    // R9: level equal to mask refused, then level 0 refused with mask 0
    imask = 4'd5; perReq = 13'h0100; perLevel = allLvl(4'd5); extLevel = 4'd5;
    apply("R9");
    imask = 4'd0; perLevel = allLvl(4'd0); perReq = 13'h1FFF; apply("R9");
    // R3: debug break both ways
    brkReq = 1; dbgRedirect = 1; excReq = 1; extLevel = 4'd9; apply("R3");
    brkReq = 1; dbgRedirect = 0; apply("R3");
    // R2: exception over interrupt
    excReq = 1; excCode = 12'h0E0; extLevel = 4'd12; apply("R2");
    // R1: reset over everything
    resetReq = 1; brkReq = 1; excReq = 1; extLevel = 4'd15; apply("R1");
    // R4: interrupt leaves exception code intact
    extLevel = 4'd4; apply("R4");

    // R10: request held for two edges is accepted once
    perReq = 13'h0001; perLevel = allLvl(4'd6); model();
    @(posedge clk); #1;
    chk(taken == 1, "R10", "first edge", 32'(taken), 32'd1);
    @(posedge clk); #1;
    chk(taken == 0, "R10", "held request ignored", 32'(taken), 32'd0);
    @(negedge clk); perReq = 0;
    @(posedge clk); #1;
    @(negedge clk);

    // random mix
    for (int n = 0; n < 600; n++) begin
      resetReq    = ($urandom % 40) == 0;
      brkReq      = ($urandom % 20) == 0;
      excReq      = ($urandom % 10) == 0;
      excCode     = 12'($urandom);
      dbgRedirect = 1'($urandom);
      extLevel    = (($urandom % 3) == 0) ? 4'($urandom) : 4'd0;
      perReq      = 13'($urandom & $urandom);
      perLevel    = {20'($urandom), 32'($urandom)};
      imask       = 4'($urandom % 8);
      vbr         = $urandom & 32'hFFFF_FF00;
      dbr         = $urandom;
      apply("");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule